// File: doc/BRIEF.md
# Seconds Real-Time Counter with Match Alarms

This block keeps time as a count of seconds. A 32-bit up-counter advances once per second and a second 32-bit counter runs down beside it. Software loads the down-counter with the bitwise complement of the up-count, and the two then stay complementary. A one-cycle `sec_tick` pulse stands in for the prescaled slow clock.

Two match registers are compared against the up-counter. On a hit, each one sets a status latch. The latch drives the interrupt output when its enable bit is set. A hit can also be routed to a power-switch status latch. A control register can pause both counters, so a pair of loads is atomic with respect to ticks, or hold them in a soft reset. A free scratch key register lets boot software see whether the block was already set up; the conventional marker is 0xB5C13F27.

The counting engine is a three-state machine:
- **ST_RUN**: ticks advance the counters.
- **ST_HALT**: the counters are frozen and can be loaded.
- **ST_SRST**: the counters are forced to their cleared values.

The next state comes from the control value being committed on the same edge:
- **pause** (ST_RUN to ST_HALT)
- **resume** (ST_HALT to ST_RUN)
- **enter_reset** (any state to ST_SRST)
- **release** (ST_SRST to ST_RUN or ST_HALT)

The register bus is single-cycle: writes commit on the clock edge and reads are combinational on the address.

Top module: `secs_rtc`

## Requirements
- R1: After hardware reset, the registers read as follows: control 0, status 0, both match registers 0xFFFFFFFF, key 0, up-counter 0, down-counter 0xFFFFFFFF.
- R2: In ST_RUN (control bit4 and bit6 clear), each cycle with `sec_tick` high increments the up-counter (offset 0x00) and decrements the down-counter (offset 0x04), both wrapping modulo 2^32.
- R3: While control bit6 (0x40) is set, ticks have no effect on either counter. A bus write to offset 0x00 or 0x04 loads that counter directly, and a counter write takes priority over a tick in the same cycle.
- R4: While control bit4 (0x10) is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF, and writes to them are ignored. Key, match and control keep their values.
- R5: When a tick makes the up-counter equal to match0 (offset 0x08) or match1 (offset 0x0C), status bit0 or bit1 (offset 0x14) is set. This happens whether or not the match is enabled.
- R6: A match register holding 0xFFFFFFFF never sets its status bit, even when the up-counter wraps through that value.
- R7: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A hit in the same cycle wins over the clear.
- R8: `irq` is high exactly when (status bit0 AND control bit0) OR (status bit1 AND control bit1).
- R9: Status bit2 is set by a match0 hit with control bit2 set, by a match1 hit with control bit3 set, or on every cycle with control bit7 set.
- R10: The key register (offset 0x18) reads back what was written. Control reads back the written value masked with 0xDF (bit5 reads 0). Unmapped offsets read 0.
- R11: While counting and not loaded, the sum of the up- and down-counters is unchanged by a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low hardware reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Enabled-match interrupt |

## Verification
A wrong state-machine state shows up on the first tick as a counter that moves when it should hold, or holds when it should move. It can be read back on the next cycle. A corrupted match or status latch appears on `irq` and on status reads in the cycle right after the offending tick. A broken complement pairing shows as a down-count mismatch on the first read after any tick. The bench reads one register on every cycle and compares it, together with `irq`, against its own model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_MATCH = 2;

    localparam int OFS_UP    = 'h00;
    localparam int OFS_DN    = 'h04;
    localparam int OFS_MATCH = 'h08;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_STAT  = 'h14;
    localparam int OFS_KEY   = 'h18;

    localparam int CB_EN0    = 0;
    localparam int CB_EN1    = 1;
    localparam int CB_SW0    = 2;
    localparam int CB_SW1    = 3;
    localparam int CB_SRST   = 4;
    localparam int CB_HALT   = 6;
    localparam int CB_FORCE  = 7;
    localparam logic [7:0] CTRL_MASK = 8'hDF;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_SRST = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/rtc_count_fsm.sv
module rtc_count_fsm
    import rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         srst_nxt_i,
    input  logic         halt_nxt_i,
    input  logic         ld_up_i,
    input  logic         ld_dn_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] up_o,
    output logic [W-1:0] dn_o,
    output logic         up_step_o,
    output logic         srst_o
);
    localparam logic [W-1:0] ONES = '1;

    cnt_state_e state_q, state_d;
    logic       dn_step;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (srst_nxt_i) state_d = ST_SRST;
                     else if (halt_nxt_i) state_d = ST_HALT;
            ST_HALT: if (srst_nxt_i) state_d = ST_SRST;
                     else if (!halt_nxt_i) state_d = ST_RUN;
            ST_SRST: if (!srst_nxt_i) state_d = halt_nxt_i ? ST_HALT : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        up_step_o = (state_q == ST_RUN) && tick_i && !ld_up_i;
        dn_step   = (state_q == ST_RUN) && tick_i && !ld_dn_i;
        srst_o    = (state_q == ST_SRST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_o <= '0;
            dn_o <= ONES;
        end else if (srst_o) begin
            up_o <= '0;
            dn_o <= ONES;
        end else begin
            if (ld_up_i)        up_o <= ld_val_i;
            else if (up_step_o) up_o <= up_o + 1'b1;
            if (ld_dn_i)        dn_o <= ld_val_i;
            else if (dn_step)   dn_o <= dn_o - 1'b1;
        end
    end

    AST_RUN_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        up_step_o |=> up_o == $past(up_o) + 1'b1); // R2
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !ld_up_i) |=> $stable(up_o)); // R3
    AST_PAIR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (up_step_o && dn_step) |=> (up_o + dn_o) == $past(up_o + dn_o)); // R11
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         step_i,
    input  logic [W-1:0] up_i,
    input  logic         clr_i,
    output logic [W-1:0] val_o,
    output logic         hit_o,
    output logic         stat_o
);
    localparam logic [W-1:0] ONES = '1;

    always_comb hit_o = step_i && ((up_i + 1'b1) == val_o) && (val_o != ONES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_o  <= ONES;
            stat_o <= 1'b0;
        end else begin
            if (wr_i) val_o <= wdata_i;
            if (hit_o)      stat_o <= 1'b1;
            else if (clr_i) stat_o <= 1'b0;
        end
    end

    AST_DEAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (val_o == ONES && !clr_i) |=> $stable(stat_o)); // R6
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_o) |=> !stat_o); // R7
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [7:0]        ctrl_q, ctrl_d;
    logic [DATA_W-1:0] key_q;
    logic              onsw_q;
    logic [DATA_W-1:0] up_w, dn_w;
    logic              up_step, srst_w;
    logic              wr_up, wr_dn, wr_ctrl, wr_stat, wr_key;
    logic [DATA_W-1:0] match_val [NUM_MATCH];
    logic [NUM_MATCH-1:0] hit, stat;

    always_comb begin
        wr_up   = bus_we && bus_addr == ADDR_W'(OFS_UP);
        wr_dn   = bus_we && bus_addr == ADDR_W'(OFS_DN);
        wr_ctrl = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
        wr_stat = bus_we && bus_addr == ADDR_W'(OFS_STAT);
        wr_key  = bus_we && bus_addr == ADDR_W'(OFS_KEY);
        ctrl_d  = wr_ctrl ? (bus_wdata[7:0] & CTRL_MASK) : ctrl_q;
    end

    rtc_count_fsm #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (sec_tick),
        .srst_nxt_i (ctrl_d[CB_SRST]),
        .halt_nxt_i (ctrl_d[CB_HALT]),
        .ld_up_i    (wr_up && !srst_w),
        .ld_dn_i    (wr_dn && !srst_w),
        .ld_val_i   (bus_wdata),
        .up_o       (up_w),
        .dn_o       (dn_w),
        .up_step_o  (up_step),
        .srst_o     (srst_w)
    );

    for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
        rtc_match_unit #(.W(DATA_W)) u_m (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (bus_we && bus_addr == ADDR_W'(OFS_MATCH + 4*i)),
            .wdata_i (bus_wdata),
            .step_i  (up_step),
            .up_i    (up_w),
            .clr_i   (wr_stat && bus_wdata[i]),
            .val_o   (match_val[i]),
            .hit_o   (hit[i]),
            .stat_o  (stat[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            key_q  <= '0;
            onsw_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_key) key_q <= bus_wdata;
            if ((hit[0] && ctrl_q[CB_SW0]) || (hit[1] && ctrl_q[CB_SW1]) || ctrl_q[CB_FORCE])
                onsw_q <= 1'b1;
            else if (wr_stat && bus_wdata[NUM_MATCH])
                onsw_q <= 1'b0;
        end
    end

    always_comb begin
        irq = (stat[0] && ctrl_q[CB_EN0]) || (stat[1] && ctrl_q[CB_EN1]);
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_UP):        bus_rdata = up_w;
            ADDR_W'(OFS_DN):        bus_rdata = dn_w;
            ADDR_W'(OFS_MATCH):     bus_rdata = match_val[0];
            ADDR_W'(OFS_MATCH + 4): bus_rdata = match_val[1];
            ADDR_W'(OFS_CTRL):      bus_rdata = {24'd0, ctrl_q};
            ADDR_W'(OFS_STAT):      bus_rdata = {29'd0, onsw_q, stat};
            ADDR_W'(OFS_KEY):       bus_rdata = key_q;
            default:                bus_rdata = '0;
        endcase
    end

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_up && ctrl_q[CB_SRST] && ctrl_d[CB_SRST]) |=> up_w == '0); // R4
    AST_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_key |=> key_q == $past(bus_wdata)); // R10
    AST_FORCE_SW: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CB_FORCE] |=> onsw_q); // R9
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b00) |-> !irq); // R8
endmodule

// File: tb/secs_rtc_tb_top.sv
`timescale 1ns/1ps
module secs_rtc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    bit [31:0] m_up, m_dn, m_key;
    bit [31:0] m_match [2];
    bit [7:0]  m_ctrl;
    bit [2:0]  m_st;

    always #2.5 clk = ~clk;

    secs_rtc dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic bit [31:0] model_read(input bit [4:0] a);
        case (a)
            5'h00: return m_up;
            5'h04: return m_dn;
            5'h08: return m_match[0];
            5'h0C: return m_match[1];
            5'h10: return {24'd0, m_ctrl};
            5'h14: return {29'd0, m_st};
            5'h18: return m_key;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_up = 0; m_dn = 32'hFFFFFFFF; m_key = 0; m_ctrl = 0; m_st = 0;
        m_match[0] = 32'hFFFFFFFF; m_match[1] = 32'hFFFFFFFF;
    endtask

    task automatic model_clock(input bit t, input bit w, input bit [4:0] a, input bit [31:0] d);
        bit srst, run, hit0, hit1, ldu, ldd;
        bit [31:0] nu, nd;
        srst = m_ctrl[4];
        run  = !m_ctrl[4] && !m_ctrl[6];
        ldu  = w && a == 5'h00 && !srst;
        ldd  = w && a == 5'h04 && !srst;
        hit0 = run && t && !ldu && (m_up + 1 == m_match[0]) && m_match[0] != 32'hFFFFFFFF;
        hit1 = run && t && !ldu && (m_up + 1 == m_match[1]) && m_match[1] != 32'hFFFFFFFF;
        nu = m_up; nd = m_dn;
        if (srst) begin nu = 0; nd = 32'hFFFFFFFF; end
        else begin
            if (ldu) nu = d; else if (run && t) nu = m_up + 1;
            if (ldd) nd = d; else if (run && t) nd = m_dn - 1;
        end
        if (w && a == 5'h14) m_st = m_st & ~d[2:0];
        if (hit0) m_st[0] = 1;
        if (hit1) m_st[1] = 1;
        if ((hit0 && m_ctrl[2]) || (hit1 && m_ctrl[3]) || m_ctrl[7]) m_st[2] = 1;
        if (w && a == 5'h10) m_ctrl = d[7:0] & 8'hDF;
        if (w && a == 5'h08) m_match[0] = d;
        if (w && a == 5'h0C) m_match[1] = d;
        if (w && a == 5'h18) m_key = d;
        m_up = nu; m_dn = nd;
    endtask

    task automatic step(input string tag, input bit t, input bit w, input bit [4:0] a, input bit [31:0] d);
        bit exp_irq;
        @(negedge clk);
        sec_tick = t; bus_we = w; bus_addr = a; bus_wdata = d;
        #1;
        exp_irq = (m_st[0] && m_ctrl[0]) || (m_st[1] && m_ctrl[1]);
        n_vec++;
        if (bus_rdata !== model_read(a) || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b", tag, a, bus_rdata, model_read(a), irq, exp_irq);
        end
        @(posedge clk);
        model_clock(t, w, a, d);
    endtask

    task automatic rd(input string tag, input bit [4:0] a);
        step(tag, 0, 0, a, 0);
    endtask

    task automatic wr(input string tag, input bit [4:0] a, input bit [31:0] d);
        step(tag, 0, 1, a, d);
    endtask

    task automatic ticks(input string tag, input int n, input bit [4:0] a);
        for (int k = 0; k < n; k++) step(tag, 1, 0, a, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset values
        for (int a = 0; a < 32; a += 4) rd("R1", 5'(a));
        // R10 key and control mask, unmapped
        wr("R10", 5'h18, 32'hB5C13F27); rd("R10", 5'h18);
        wr("R10", 5'h10, 32'h0000_00E0); rd("R10", 5'h10); rd("R10", 5'h1C);
        wr("R10", 5'h10, 32'h0); ticks("R9", 1, 5'h14); wr("R7", 5'h14, 32'h4); rd("R7", 5'h14);
        // R2 / R11 counting
        ticks("R2", 4, 5'h00); ticks("R11", 3, 5'h04);
        // R3 halt and atomic load
        wr("R3", 5'h10, 32'h40); ticks("R3", 3, 5'h00);
        wr("R3", 5'h00, 32'd100); wr("R3", 5'h04, 32'hFFFFFFFF - 32'd100);
        ticks("R3", 2, 5'h04); wr("R3", 5'h10, 32'h0);
        step("R3", 1, 1, 5'h00, 32'd500); rd("R3", 5'h00); rd("R11", 5'h04);
        // R5 / R8 match0 enabled
        wr("R5", 5'h08, 32'd503); wr("R8", 5'h10, 32'h01);
        ticks("R5", 3, 5'h14); rd("R8", 5'h14); rd("R8", 5'h14);
        // R7 clear, set-wins
        wr("R7", 5'h14, 32'h1); rd("R7", 5'h14);
        // R5 match1 not enabled, routed to power switch (R9)
        wr("R9", 5'h0C, 32'd505); wr("R9", 5'h10, 32'h08);
        ticks("R5", 2, 5'h14); rd("R9", 5'h14);
        wr("R8", 5'h10, 32'h0A); rd("R8", 5'h14);
        wr("R7", 5'h10, 32'h00); wr("R7", 5'h0C, 32'd507);
        step("R7", 1, 1, 5'h14, 32'h7); rd("R7", 5'h14);
        wr("R7", 5'h14, 32'h7); rd("R7", 5'h14);
        // R9 match0 routed
        wr("R9", 5'h08, 32'd509); wr("R9", 5'h10, 32'h04); ticks("R9", 2, 5'h14);
        wr("R9", 5'h14, 32'h7); wr("R9", 5'h10, 32'h80); rd("R9", 5'h14);
        wr("R9", 5'h14, 32'h4); rd("R9", 5'h14); wr("R9", 5'h10, 32'h00);
        wr("R9", 5'h14, 32'h7); rd("R9", 5'h14);
        // R6 dead match across wrap
        wr("R6", 5'h08, 32'hFFFFFFFF); wr("R6", 5'h0C, 32'h00000001); wr("R6", 5'h10, 32'h03);
        wr("R6", 5'h00, 32'hFFFFFFFD);
        ticks("R6", 4, 5'h14); rd("R6", 5'h00); rd("R2", 5'h04);
        wr("R6", 5'h14, 32'h7);
        // R4 soft reset hold
        wr("R4", 5'h00, 32'd1234); wr("R4", 5'h10, 32'h13);
        ticks("R4", 3, 5'h00); wr("R4", 5'h00, 32'd77); rd("R4", 5'h00); rd("R4", 5'h04);
        rd("R4", 5'h18); rd("R4", 5'h08); rd("R4", 5'h10);
        wr("R4", 5'h10, 32'h00); ticks("R4", 2, 5'h00); rd("R11", 5'h04);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule